// File: doc/BRIEF.md
# Watchdog Timer with Programmable External Reset Pulse

This block is a countdown watchdog on a small word-addressed register bus. Software loads a reload value and switches the counter on. From then on it counts down once per clock, or once per 1 MHz tick strobe. Before it runs out, software must write a fixed restart key, which puts the reload value back into the counter. If the count runs out, the block raises a one-cycle reset request that carries a reset kind, a one-cycle interrupt, or both. It can also start an external reset pulse whose length is a programmed number of microsecond ticks.

The external pin has two settings: polarity (active-high or active-low) and drive style (push-pull or open-drain). Only keyed values in the top byte of the width register can change them. Any other top-byte value leaves them as they are. The width bits below the top byte are written on every access. The block presents the pin as a data value and an output enable. The pad and the routing of the reset request are outside this block.

Register word offsets: 0 reads the live count, 1 is the reload value, 2 is the restart register (write-only, reads 0), 3 is control, and 4 is the pulse width with the pin settings. Any other offset reads 0.

Top module: `wdog_pulse_top`

## Requirements
- R1: After reset, the count, reload and control registers read 0 and the width register reads 0x000000FF (active-low, open-drain). `rstReq` and `irqOut` are low, and the pin is released (`extOe`=0, `extOut`=0).
- R2: A control write that sets bit 0 while it was clear copies the reload value into the counter. While bit 0 is set, the counter steps down once per clock when bit 4 is clear, and once per `tickUs` strobe when bit 4 is set. With reload value N≥1, expiry comes on the Nth step after loading; a reload of 0 behaves like 1. On expiry the counter reloads and keeps running.
- R3: On expiry, `rstReq` pulses for one cycle if control bit 1 is set, and `irqOut` pulses for one cycle if control bit 2 is set. Each follows only its own bit.
- R4: Writing exactly 0x00004755 to offset 2 copies the reload value into the counter. Any other value written there has no effect on the count. Offset 0 reads the live count.
- R5: If control bit 3 is set at expiry, the external pin is asserted for exactly W+1 `tickUs` strobes, where W is width bits [19:0] at offset 4. W=0 gives one strobe.
- R6: An expiry while a pulse is active does not restart or lengthen that pulse.
- R7: A write to offset 4 always updates width bits [19:0]; bits [23:20] are ignored. A top byte of 0xA5 sets active-high and 0x5A sets active-low, read back on bit 31. A top byte of 0xA8 sets push-pull and 0x8A sets open-drain, read back on bit 30. Any other top byte leaves both settings unchanged.
- R8: Pin shaping: the level is the pulse state for active-high and its inverse for active-low. Push-pull gives `extOe`=1 and `extOut`=level. Open-drain gives `extOut`=0 and `extOe`=NOT level.
- R9: If control bit 3 is clear, an expiry does not assert the external pin.
- R10: `rstKind`, captured at expiry, decodes control bits [6:5]: 0 gives 0 (SoC reset), 1 gives 1 (full-chip reset), and 2 or 3 give 2 (CPU-only reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickUs | input | 1 | 1 MHz tick strobe, one clock wide |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| rstReq | output | 1 | One-cycle reset request on expiry |
| rstKind | output | 2 | Reset kind captured at expiry |
| irqOut | output | 1 | One-cycle interrupt on expiry |
| extOut | output | 1 | External reset pin data |
| extOe | output | 1 | External reset pin output enable |

## Verification
The timeout is swept over reload values 0 to 6 in clock mode and 1 to 5 in tick mode, with each reset-mode encoding. This separates an off-by-one in the expiry compare from a wrong step source or a wrong kind decode. The pulse is measured for widths 0, 1, 2, 5 and 255, with a reload of 1 and with a long reload. The short reload makes expiries land inside the active pulse, which exposes any retrigger that the long reload hides. The keyed writes mix each magic byte with a non-magic one, and the pin is checked in all four polarity and drive combinations, both idle and during a pulse. Restart writes with a near-miss key and with a wrong upper half show that only the exact key reloads.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [31:0] KICK_KEY       = 32'h0000_4755;
  localparam logic [7:0]  KEY_POL_HIGH   = 8'hA5;
  localparam logic [7:0]  KEY_POL_LOW    = 8'h5A;
  localparam logic [7:0]  KEY_PUSH_PULL  = 8'hA8;
  localparam logic [7:0]  KEY_OPEN_DRAIN = 8'h8A;

  localparam logic [2:0] ADDR_COUNT  = 3'd0;
  localparam logic [2:0] ADDR_RELOAD = 3'd1;
  localparam logic [2:0] ADDR_KICK   = 3'd2;
  localparam logic [2:0] ADDR_CTRL   = 3'd3;
  localparam logic [2:0] ADDR_WIDTH  = 3'd4;

  typedef enum logic [1:0] {
    KIND_SOC  = 2'd0,
    KIND_CHIP = 2'd1,
    KIND_CPU  = 2'd2
  } rstKindT;

  // strobes from register control into the datapath
  typedef struct packed {
    logic loadCount;
  } strobeT;

  typedef struct packed {
    logic       enable;
    logic       rstEn;
    logic       irqEn;
    logic       extEn;
    logic       tickSel;
    logic [1:0] mode;
    logic       polHigh;
    logic       pushPull;
  } cfgT;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W  = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [CNT_W-1:0] count,
  output strobeT           strobe,
  output cfgT              cfg,
  output logic [CNT_W-1:0] reloadVal,
  output logic [PW_W-1:0]  widthVal
);
  localparam int CTRL_W = 7;
  localparam logic [PW_W-1:0] WIDTH_RST = PW_W'(8'hFF);

  logic [CTRL_W-1:0] ctrlReg;
  logic polHigh;
  logic pushPull;
  logic wrReload, wrKick, wrCtrl, wrWidth;
  logic [7:0] topByte;

  assign wrReload = regWr && (regAddr == ADDR_RELOAD);
  assign wrKick   = regWr && (regAddr == ADDR_KICK);
  assign wrCtrl   = regWr && (regAddr == ADDR_CTRL);
  assign wrWidth  = regWr && (regAddr == ADDR_WIDTH);
  assign topByte  = regWdata[31:24];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      reloadVal <= '0;
      widthVal  <= WIDTH_RST;
      polHigh   <= 1'b0;
      pushPull  <= 1'b0;
    end else begin
      if (wrReload) reloadVal <= regWdata[CNT_W-1:0];
      if (wrCtrl)   ctrlReg   <= regWdata[CTRL_W-1:0];
      if (wrWidth) begin
        widthVal <= regWdata[PW_W-1:0];
        case (topByte)
          KEY_POL_HIGH:   polHigh  <= 1'b1;
          KEY_POL_LOW:    polHigh  <= 1'b0;
          KEY_PUSH_PULL:  pushPull <= 1'b1;
          KEY_OPEN_DRAIN: pushPull <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.loadCount = (wrKick && (regWdata == KICK_KEY)) ||
                       (wrCtrl && regWdata[0] && !ctrlReg[0]);
    cfg.enable   = ctrlReg[0];
    cfg.rstEn    = ctrlReg[1];
    cfg.irqEn    = ctrlReg[2];
    cfg.extEn    = ctrlReg[3];
    cfg.tickSel  = ctrlReg[4];
    cfg.mode     = ctrlReg[6:5];
    cfg.polHigh  = polHigh;
    cfg.pushPull = pushPull;
  end

  always_comb begin
    case (regAddr)
      ADDR_COUNT:  regRdata = 32'(count);
      ADDR_RELOAD: regRdata = 32'(reloadVal);
      ADDR_CTRL:   regRdata = 32'(ctrlReg);
      ADDR_WIDTH:  regRdata = 32'(widthVal) | {polHigh, pushPull, 30'b0};
      default:     regRdata = '0;
    endcase
  end

  // R4: the exact key always produces a reload strobe
  assert_kick_loads_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrKick && regWdata == KICK_KEY) |-> strobe.loadCount);

  // R7: polarity only moves on its own keys
  assert_pol_keyed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrWidth && topByte != KEY_POL_HIGH && topByte != KEY_POL_LOW) |=> $stable(polHigh));

  // R7: drive mode only moves on its own keys
  assert_drive_keyed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrWidth && topByte != KEY_PUSH_PULL && topByte != KEY_OPEN_DRAIN) |=> $stable(pushPull));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W  = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickUs,
  input  strobeT           strobe,
  input  cfgT              cfg,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [PW_W-1:0]  widthVal,
  output logic [CNT_W-1:0] count,
  output logic             rstReq,
  output rstKindT          rstKind,
  output logic             irqOut,
  output logic             extOut,
  output logic             extOe
);
  logic countStep;
  logic expire;
  logic pulseActive;
  logic [PW_W-1:0] remain;
  logic extLevel;
  rstKindT kindNext;

  assign countStep = cfg.enable && (cfg.tickSel ? tickUs : 1'b1);
  assign expire    = !strobe.loadCount && countStep && (count <= CNT_W'(1));

  always_comb begin
    case (cfg.mode)
      2'd0:    kindNext = KIND_SOC;
      2'd1:    kindNext = KIND_CHIP;
      default: kindNext = KIND_CPU;
    endcase
  end

  // countdown with auto-reload on expiry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.loadCount) begin
      count <= reloadVal;
    end else if (countStep) begin
      count <= (count <= CNT_W'(1)) ? reloadVal : count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq  <= 1'b0;
      irqOut  <= 1'b0;
      rstKind <= KIND_SOC;
    end else begin
      rstReq <= expire && cfg.rstEn;
      irqOut <= expire && cfg.irqEn;
      if (expire) rstKind <= kindNext;
    end
  end

  // pulse generator: counts remaining ticks, ignores expiries while active
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseActive <= 1'b0;
      remain      <= '0;
    end else if (!pulseActive) begin
      if (expire && cfg.extEn) begin
        pulseActive <= 1'b1;
        remain      <= widthVal;
      end
    end else if (tickUs) begin
      if (remain == '0) pulseActive <= 1'b0;
      else              remain      <= remain - PW_W'(1);
    end
  end

  assign extLevel = cfg.polHigh ? pulseActive : !pulseActive;
  assign extOut   = cfg.pushPull ? extLevel : 1'b0;
  assign extOe    = cfg.pushPull ? 1'b1 : !extLevel;

  // R2: a plain step lowers the count by one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (countStep && !strobe.loadCount && count > CNT_W'(1)) |=> count == $past(count - CNT_W'(1)));

  // R3: a reset request needs the reset enable
  assert_req_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(cfg.rstEn));

  // R5: a pulse only begins when the external signal is enabled
  assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> $past(cfg.extEn));

  // R6: without a tick, an active pulse holds its remaining length
  assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && !tickUs) |=> (pulseActive && $stable(remain)));
endmodule

// File: rtl/wdog_pulse_top.sv
module wdog_pulse_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W  = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickUs,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        rstReq,
  output logic [1:0]  rstKind,
  output logic        irqOut,
  output logic        extOut,
  output logic        extOe
);
  strobeT           strobe;
  cfgT              cfg;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reloadVal;
  logic [PW_W-1:0]  widthVal;
  rstKindT          kind;

  wdog_regs #(.CNT_W(CNT_W), .PW_W(PW_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .count(count),
    .strobe(strobe), .cfg(cfg), .reloadVal(reloadVal), .widthVal(widthVal)
  );

  wdog_core #(.CNT_W(CNT_W), .PW_W(PW_W)) u_core (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .strobe(strobe), .cfg(cfg),
    .reloadVal(reloadVal), .widthVal(widthVal), .count(count),
    .rstReq(rstReq), .rstKind(kind), .irqOut(irqOut),
    .extOut(extOut), .extOe(extOe)
  );

  assign rstKind = kind;
endmodule

// File: tb/wdog_pulse_top_tb.sv
module wdog_pulse_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int GUARD      = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickUs = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic rstReq, irqOut, extOut, extOe;
  logic [1:0] rstKind;

  int checks = 0;
  int errors = 0;
  int tickTotal = 0;
  int pulseTicks = 0;
  bit seenAssert = 0;
  bit autoTick = 1;
  int manualReq = 0;
  int divCnt = 0;
  bit benchHigh = 0;
  bit benchPP = 0;

  wdog_pulse_top u_dut (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rstReq(rstReq), .rstKind(rstKind),
    .irqOut(irqOut), .extOut(extOut), .extOe(extOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (autoTick) begin
      divCnt = divCnt + 1;
      tickUs = (divCnt % TICK_DIV) == 0;
    end else if (manualReq > 0) begin
      tickUs = 1'b1;
      manualReq = manualReq - 1;
    end else begin
      tickUs = 1'b0;
    end
  end

  function automatic bit isAsserted();
    if (benchHigh) return benchPP ? (extOe && extOut) : !extOe;
    else           return benchPP ? (extOe && !extOut) : extOe;
  endfunction

  always @(posedge clk) begin
    if (tickUs) tickTotal = tickTotal + 1;
    if (tickUs && isAsserted()) pulseTicks = pulseTicks + 1;
    if (isAsserted()) seenAssert = 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic manualTick();
    manualReq = manualReq + 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitReq(output int n);
    n = 0;
    while (!rstReq && n < GUARD) begin @(negedge clk); n++; end
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irqOut && n < GUARD) begin @(negedge clk); n++; end
  endtask

  task automatic waitPulse();
    int g = 0;
    while (!isAsserted() && g < GUARD) begin @(negedge clk); g++; end
    g = 0;
    while (isAsserted() && g < 4 * GUARD) begin @(negedge clk); g++; end
  endtask

  task automatic checkIdlePins(input string req);
    bit level = benchHigh ? 1'b0 : 1'b1;
    bit expOut = benchPP ? level : 1'b0;
    bit expOe  = benchPP ? 1'b1 : !level;
    check(extOut == expOut, req, 32'(extOut), 32'(expOut));
    check(extOe == expOe, req, 32'(extOe), 32'(expOe));
  endtask

  task automatic keyedWrite(input logic [31:0] d, input logic [31:0] expRd, input bit h, input bit pp);
    logic [31:0] v;
    wr(3'd4, d);
    benchHigh = h; benchPP = pp;
    rd(3'd4, v);
    check(v == expRd, "R7 width/key readback", v, expRd);
    checkIdlePins("R8 idle pin");
  endtask

  task automatic pulseRun(input int w, input int reload);
    wr(3'd4, 32'(w));
    wr(3'd1, 32'(reload));
    @(negedge clk);
    pulseTicks = 0;
    wr(3'd3, 32'h19);  // enable, external, tick mode
    waitPulse();
    check(pulseTicks == w + 1, "R5/R6 pulse length", 32'(pulseTicks), 32'(w + 1));
    wr(3'd3, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    int t0;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check(v == 0, "R1 count", v, 0);
    rd(3'd1, v); check(v == 0, "R1 reload", v, 0);
    rd(3'd3, v); check(v == 0, "R1 ctrl", v, 0);
    rd(3'd4, v); check(v == 32'hFF, "R1 width", v, 32'hFF);
    check(rstReq == 0, "R1 rstReq", 32'(rstReq), 0);
    check(irqOut == 0, "R1 irqOut", 32'(irqOut), 0);
    check(extOe == 0, "R1 extOe", 32'(extOe), 0);
    check(extOut == 0, "R1 extOut", 32'(extOut), 0);

    // R7 / R8 keyed top byte and pin shaping at idle
    keyedWrite(32'h00FF_FFFF, 32'h000F_FFFF, 0, 0);
    keyedWrite(32'h0000_0010, 32'h0000_0010, 0, 0);
    keyedWrite(32'hA500_0003, 32'h8000_0003, 1, 0);
    keyedWrite(32'hA800_0007, 32'hC000_0007, 1, 1);
    keyedWrite(32'h1200_0009, 32'hC000_0009, 1, 1);
    keyedWrite(32'h5A00_0001, 32'h4000_0001, 0, 1);
    keyedWrite(32'h8A00_0002, 32'h0000_0002, 0, 0);

    // R2 clock-mode sweep, reload 0 acts as 1
    for (int k = 0; k <= 6; k++) begin
      wr(3'd1, 32'(k));
      wr(3'd3, 32'h3);
      waitReq(n);
      check(n == ((k == 0) ? 1 : k), "R2 clock-mode expiry", 32'(n), 32'((k == 0) ? 1 : k));
      wr(3'd3, 32'h0);
    end

    // R2 / R10 tick-mode sweep with each mode encoding
    for (int k = 1; k <= 5; k++) begin
      for (int m = 0; m < 4; m++) begin
        wr(3'd1, 32'(k));
        wr(3'd3, 32'h13 | (32'(m) << 5));
        t0 = tickTotal;
        waitReq(n);
        check(tickTotal - t0 == k, "R2 tick-mode expiry", 32'(tickTotal - t0), 32'(k));
        check(rstKind == ((m >= 2) ? 2'd2 : 2'(m)), "R10 reset kind", 32'(rstKind),
              32'((m >= 2) ? 2 : m));
        wr(3'd3, 32'h0);
      end
    end

    // R4 readback and restart key, manual ticks
    autoTick = 0;
    @(negedge clk);
    wr(3'd1, 32'd50);
    wr(3'd3, 32'h11);
    rd(3'd0, v); check(v == 50, "R4 loaded count", v, 50);
    repeat (5) manualTick();
    rd(3'd0, v); check(v == 45, "R4 count after ticks", v, 45);
    wr(3'd2, 32'h0000_1234);
    rd(3'd0, v); check(v == 45, "R4 wrong key ignored", v, 45);
    wr(3'd2, 32'h0001_4755);
    rd(3'd0, v); check(v == 45, "R4 wrong upper ignored", v, 45);
    wr(3'd2, 32'h0000_4755);
    rd(3'd0, v); check(v == 50, "R4 key reloads", v, 50);
    wr(3'd3, 32'h0);
    autoTick = 1;

    // R3 irq alone, then both
    wr(3'd1, 32'd3);
    wr(3'd3, 32'h15);
    waitIrq(n);
    check(irqOut == 1, "R3 irq fires", 32'(irqOut), 1);
    check(rstReq == 0, "R3 no request without bit1", 32'(rstReq), 0);
    wr(3'd3, 32'h0);
    wr(3'd3, 32'h17);
    waitReq(n);
    check(rstReq == 1, "R3 request fires", 32'(rstReq), 1);
    check(irqOut == 1, "R3 irq with request", 32'(irqOut), 1);
    @(negedge clk);
    check(rstReq == 0, "R3 request one cycle", 32'(rstReq), 0);
    wr(3'd3, 32'h0);

    // R5 / R6 pulse widths, long and short reload (active-low open-drain)
    foreach (v[i]) if (i < 0) v = 0;
    pulseRun(0, 1);
    pulseRun(0, 40);
    pulseRun(1, 1);
    pulseRun(2, 40);
    pulseRun(5, 1);
    pulseRun(5, 40);
    pulseRun(255, 1);

    // R8 pulse in active-high push-pull and active-high open-drain
    keyedWrite(32'hA500_0003, 32'h8000_0003, 1, 0);
    pulseRun(3, 1);
    keyedWrite(32'hA800_0003, 32'hC000_0003, 1, 1);
    pulseRun(3, 1);
    keyedWrite(32'h5A00_0002, 32'h4000_0002, 0, 1);
    pulseRun(2, 40);

    // R9 external signal disabled
    wr(3'd1, 32'd2);
    @(negedge clk);
    seenAssert = 0;
    wr(3'd3, 32'h13);
    waitReq(n);
    repeat (40) @(negedge clk);
    check(seenAssert == 0, "R9 no pulse without bit3", 32'(seenAssert), 0);
    wr(3'd3, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule